// File: doc/BRIEF.md
# Port Interrupt Status Register Unit

This unit holds the interrupt state of one storage host port. Single-cycle event pulses from the port logic set sticky status bits. A status read returns each event twice: unmasked in the upper half-word, and ANDed with a per-event enable in the lower half-word. The port interrupt line is the OR of the enabled events, and a host aggregator collects it.

Software changes enables through two write-only views: one sets bits and one clears bits, so no read-modify-write is needed. A two-bit routing field travels in the top bits of the same writes. A mode bit in the control word selects how status is acknowledged. In one mode a status read consumes the bits it returned. In the other mode software writes ones to the bits it wants to clear.

Top module: `port_irq_regs`

## Requirements
- R1: After reset the status word, the enable word, the routing field and the control word all read 0, and `irq_o` is 0.
- R2: A 1 on `evt_i[i]` for one cycle sets raw status bit i, read at status word bit i+16. The implemented events are at bits 0 through 6 and at bit 11.
- R3: Status word bits 11:0 equal the raw bits ANDed with the enable bits. Event inputs 7 to 10 never set any status bit.
- R4: A write to address 2 sets each enable bit i (bits 11:0) that is 1 in the data and leaves the others unchanged. A read of address 2 or 3 returns the enables in bits 11:0 and the routing field in bits 31:30.
- R5: A write to address 3 clears each enable bit that is 1 in the data and leaves the others unchanged.
- R6: The routing field is set per bit by data bits 31:30 of an address-2 write and cleared per bit by data bits 31:30 of an address-3 write. It drives `steer_o`.
- R7: With control bit 3 = 1, a write to address 1 clears raw bit i when data bit i or data bit i+16 is 1, and leaves the other bits set. Reads of the status word do not clear anything in this mode.
- R8: With control bit 3 = 0, a read of address 1 clears every raw bit it returned. Writes to address 1 have no effect in this mode.
- R9: An event that arrives in the same cycle as a clear of its bit, by read or by write, leaves the bit set.
- R10: `irq_o` is 1 exactly when some bit of status field 11:0 is 1. It follows a register change in the same cycle.
- R11: Address 0 is the control word. Only bit 3 is stored, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 12 | Event pulses, one bit per event position |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 enable set, 3 enable clear |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the registers |
| steer_o | output | 2 | Interrupt routing field |
| irq_o | output | 1 | Port interrupt to the host aggregator |

## Verification
The hardest case is an event pulse that lands in the same clock as the clear of its own bit. A read in clear-on-read mode or a one-write in write-one-to-clear mode must lose to the new event. The stimulus gets there by driving `evt_i` and the register strobe on the same falling edge, in both modes. It then reads the status word back, so a dropped event shows at the port. Checks against an all-ones event vector and against status writes in the wrong mode show that unimplemented positions and mode-gated clears leave the state untouched.

// File: rtl/port_irq_pkg.sv
package port_irq_pkg;
   localparam int unsigned REG_CTRL  = 0;
   localparam int unsigned REG_STAT  = 1;
   localparam int unsigned REG_ENSET = 2;
   localparam int unsigned REG_ENCLR = 3;
   localparam int unsigned W1C_BIT   = 3;
   localparam logic [11:0] DEF_EVT_MASK = 12'h87F;
endpackage

// File: rtl/pirq_evt_latch.sv
module pirq_evt_latch #(
   parameter int unsigned EVT_W = 12,
   parameter logic [EVT_W-1:0] EVT_MASK = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_i,
   input  logic [EVT_W-1:0] clr_i,
   output logic [EVT_W-1:0] raw_o
);
   for (genvar g = 0; g < EVT_W; g++) begin : g_bit
      if (EVT_MASK[g]) begin : g_impl
         logic st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= 1'b0;
            else        st_q <= (st_q & ~clr_i[g]) | evt_i[g];
         end
         assign raw_o[g] = st_q;

         assert_evt_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[g] |=> raw_o[g]);  // covers R9 as well: an event beats a clear
         assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[g] && !evt_i[g]) |=> !raw_o[g]);
      end else begin : g_none
         assign raw_o[g] = 1'b0;
      end
   end
endmodule

// File: rtl/pirq_enable.sv
module pirq_enable #(
   parameter int unsigned EVT_W   = 12,
   parameter int unsigned STEER_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [EVT_W-1:0]   en_bits,
   input  logic [STEER_W-1:0] steer_bits,
   output logic [EVT_W-1:0]   en_o,
   output logic [STEER_W-1:0] steer_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_o    <= '0;
         steer_o <= '0;
      end else if (set_we) begin
         en_o    <= en_o | en_bits;
         steer_o <= steer_o | steer_bits;
      end else if (clr_we) begin
         en_o    <= en_o & ~en_bits;
         steer_o <= steer_o & ~steer_bits;
      end
   end

   assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((en_o & $past(en_bits)) == $past(en_bits)));
   assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && !set_we) |=> ((en_o & $past(en_bits)) == '0));
   assert_steer_R6: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((steer_o & $past(steer_bits)) == $past(steer_bits)));
endmodule

// File: rtl/pirq_clear_ctl.sv
module pirq_clear_ctl #(
   parameter int unsigned EVT_W     = 12,
   parameter int unsigned RAW_SHIFT = 16,
   parameter int unsigned DATA_W    = 32
) (
   input  logic              w1c_mode,
   input  logic              stat_wr,
   input  logic              stat_rd,
   input  logic [DATA_W-1:0] wdata,
   input  logic [EVT_W-1:0]  raw,
   output logic [EVT_W-1:0]  clr_o
);
   always_comb begin
      clr_o = '0;
      if (w1c_mode) begin
         if (stat_wr) clr_o = wdata[EVT_W-1:0] | wdata[RAW_SHIFT +: EVT_W];
      end else if (stat_rd) begin
         clr_o = raw;
      end
   end
endmodule

// File: rtl/port_irq_regs.sv
module port_irq_regs
   import port_irq_pkg::*;
#(
   parameter int unsigned EVT_W     = 12,
   parameter int unsigned RAW_SHIFT = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned STEER_W   = 2,
   parameter int unsigned ADDR_W    = 2,
   parameter logic [EVT_W-1:0] EVT_MASK = DEF_EVT_MASK
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [EVT_W-1:0]   evt_i,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   output logic [STEER_W-1:0] steer_o,
   output logic               irq_o
);
   localparam int unsigned STEER_LSB = DATA_W - STEER_W;

   if (RAW_SHIFT < EVT_W || RAW_SHIFT + EVT_W > STEER_LSB || ADDR_W < 2
       || W1C_BIT >= DATA_W) begin : g_bad_cfg
      $error("port_irq_regs: field layout does not fit the data word");
   end

   logic              sel_ctrl, sel_stat, sel_enset, sel_enclr;
   logic              w1c_q;
   logic [EVT_W-1:0]  raw, en, masked, clr;
   logic [DATA_W-1:0] stat_word, en_word, ctrl_word;
   wire               unused_wdata = ^reg_wdata;

   assign sel_ctrl  = (reg_addr == ADDR_W'(REG_CTRL));
   assign sel_stat  = (reg_addr == ADDR_W'(REG_STAT));
   assign sel_enset = (reg_addr == ADDR_W'(REG_ENSET));
   assign sel_enclr = (reg_addr == ADDR_W'(REG_ENCLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                w1c_q <= 1'b0;
      else if (reg_wr && sel_ctrl) w1c_q <= reg_wdata[W1C_BIT];
   end

   pirq_clear_ctl #(.EVT_W(EVT_W), .RAW_SHIFT(RAW_SHIFT), .DATA_W(DATA_W)) u_clr (
      .w1c_mode (w1c_q),
      .stat_wr  (reg_wr && sel_stat),
      .stat_rd  (reg_rd && sel_stat),
      .wdata    (reg_wdata),
      .raw      (raw),
      .clr_o    (clr)
   );

   pirq_evt_latch #(.EVT_W(EVT_W), .EVT_MASK(EVT_MASK)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_i),
      .clr_i (clr),
      .raw_o (raw)
   );

   pirq_enable #(.EVT_W(EVT_W), .STEER_W(STEER_W)) u_en (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_we     (reg_wr && sel_enset),
      .clr_we     (reg_wr && sel_enclr),
      .en_bits    (reg_wdata[EVT_W-1:0]),
      .steer_bits (reg_wdata[DATA_W-1:STEER_LSB]),
      .en_o       (en),
      .steer_o    (steer_o)
   );

   assign masked    = raw & en;
   assign irq_o     = |masked;
   assign stat_word = (DATA_W'(raw) << RAW_SHIFT) | DATA_W'(masked);
   assign en_word   = (DATA_W'(steer_o) << STEER_LSB) | DATA_W'(en);
   assign ctrl_word = DATA_W'(w1c_q) << W1C_BIT;

   always_comb begin
      if (sel_ctrl)      reg_rdata = ctrl_word;
      else if (sel_stat) reg_rdata = stat_word;
      else               reg_rdata = en_word;
   end

   assert_cor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && sel_stat && !w1c_q) |=> ((raw & $past(raw) & ~$past(evt_i)) == '0));
   assert_w1c_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && !reg_wr && w1c_q) |=> ((raw & $past(raw)) == $past(raw)));
endmodule

// File: tb/port_irq_regs_test.sv
`timescale 1ns/1ps
module port_irq_regs_test;
   localparam int WD_CYCLES = 20000;
   localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EV = 2'd2, K_IRQ = 2'd3;
   localparam int NV = 39;
   // {req[3:0], kind[1:0], addr[1:0], data[31:0], expect[31:0]}
   localparam logic [71:0] VEC [NV] = '{
      {4'd1,  K_RD,  2'd0, 32'h0,         32'h0},          // R1 control
      {4'd1,  K_RD,  2'd1, 32'h0,         32'h0},          // R1 status
      {4'd1,  K_RD,  2'd2, 32'h0,         32'h0},          // R1 enables
      {4'd1,  K_IRQ, 2'd0, 32'h0,         32'h0},          // R1 irq
      {4'd2,  K_EV,  2'd0, 32'h001,       32'h0},
      {4'd2,  K_RD,  2'd1, 32'h0,         32'h0001_0000},  // R2 raw only
      {4'd8,  K_RD,  2'd1, 32'h0,         32'h0},          // R8 read cleared
      {4'd4,  K_WR,  2'd2, 32'h0803,      32'h0},
      {4'd4,  K_RD,  2'd2, 32'h0,         32'h0803},       // R4
      {4'd2,  K_EV,  2'd0, 32'h0803,      32'h0},
      {4'd3,  K_RD,  2'd1, 32'h0,         32'h0803_0803},  // R3 masked
      {4'd8,  K_RD,  2'd1, 32'h0,         32'h0},          // R8
      {4'd5,  K_WR,  2'd3, 32'h0002,      32'h0},
      {4'd5,  K_RD,  2'd3, 32'h0,         32'h0801},       // R5
      {4'd6,  K_WR,  2'd2, 32'h8000_0000, 32'h0},
      {4'd6,  K_RD,  2'd2, 32'h0,         32'h8000_0801},  // R6 set
      {4'd6,  K_WR,  2'd3, 32'h8000_0000, 32'h0},
      {4'd6,  K_WR,  2'd2, 32'h4000_0000, 32'h0},
      {4'd6,  K_RD,  2'd2, 32'h0,         32'h4000_0801},  // R6 clear then set
      {4'd3,  K_EV,  2'd0, 32'h0FFF,      32'h0},
      {4'd3,  K_RD,  2'd1, 32'h0,         32'h087F_0801},  // R3 unimplemented
      {4'd2,  K_EV,  2'd0, 32'h0004,      32'h0},
      {4'd8,  K_WR,  2'd1, 32'hFFFF_FFFF, 32'h0},
      {4'd8,  K_RD,  2'd1, 32'h0,         32'h0004_0000},  // R8 write ignored
      {4'd11, K_WR,  2'd0, 32'hFFFF_FFFF, 32'h0},
      {4'd11, K_RD,  2'd0, 32'h0,         32'h8},          // R11
      {4'd2,  K_EV,  2'd0, 32'h0030,      32'h0},
      {4'd7,  K_RD,  2'd1, 32'h0,         32'h0030_0000},  // R7
      {4'd7,  K_RD,  2'd1, 32'h0,         32'h0030_0000},  // R7 read keeps
      {4'd7,  K_WR,  2'd1, 32'h0010,      32'h0},
      {4'd7,  K_RD,  2'd1, 32'h0,         32'h0020_0000},  // R7 low field
      {4'd7,  K_WR,  2'd1, 32'h0020_0000, 32'h0},
      {4'd7,  K_RD,  2'd1, 32'h0,         32'h0},          // R7 high field
      {4'd2,  K_EV,  2'd0, 32'h0001,      32'h0},
      {4'd10, K_IRQ, 2'd0, 32'h0,         32'h1},          // R10
      {4'd10, K_RD,  2'd1, 32'h0,         32'h0001_0001},
      {4'd7,  K_WR,  2'd1, 32'hFFFF_FFFF, 32'h0},
      {4'd10, K_IRQ, 2'd0, 32'h0,         32'h0},          // R10
      {4'd7,  K_RD,  2'd1, 32'h0,         32'h0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] evt_i = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  steer_o;
   logic        irq_o;
   int checks = 0, errors = 0;

   always #2 clk = ~clk;

   port_irq_regs uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .steer_o(steer_o), .irq_o(irq_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
      @(negedge clk); reg_rd = 1'b1; reg_addr = a;
      #1 chk(req, reg_rdata, exp);
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [11:0] v);
      @(negedge clk); evt_i = v;
      @(negedge clk); evt_i = '0;
   endtask

   initial begin
      #(WD_CYCLES * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         logic [71:0] v;
         string tag;
         v = VEC[i];
         tag = $sformatf("R%0d vec%0d", v[71:68], i);
         case (v[67:66])
            K_WR:  wr(v[65:64], v[63:32]);
            K_RD:  rd(v[65:64], v[31:0], tag);
            K_EV:  pulse(v[43:32]);
            default: begin
               @(negedge clk);
               chk(tag, {31'b0, irq_o}, v[31:0]);
            end
         endcase
      end
      // R6 routing output
      chk("R6 steer_o", {30'b0, steer_o}, 32'h1);
      // R9 event races a write-one clear (w1c mode active)
      pulse(12'h002);
      @(negedge clk); reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h2; evt_i = 12'h002;
      @(negedge clk); reg_wr = 1'b0; reg_wdata = '0; evt_i = '0;
      rd(2'd1, 32'h0002_0000, "R9 w1c race");
      wr(2'd1, 32'h2);
      rd(2'd1, 32'h0, "R7 cleared after race");
      // R9 event races a clear-on-read
      wr(2'd0, 32'h0);
      pulse(12'h001);
      @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd1; evt_i = 12'h001;
      #1 chk("R9 cor race read", reg_rdata, 32'h0001_0001);
      @(negedge clk); reg_rd = 1'b0; evt_i = '0;
      rd(2'd1, 32'h0001_0001, "R9 cor race kept");
      rd(2'd1, 32'h0, "R8 cleared after race");
      // R1 reset in mid-run
      wr(2'd0, 32'h8);
      pulse(12'h801);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      rd(2'd1, 32'h0, "R1 status after reset");
      rd(2'd2, 32'h0, "R1 enables after reset");
      rd(2'd0, 32'h0, "R1 control after reset");
      @(negedge clk);
      chk("R1 irq/steer after reset", {29'b0, irq_o, steer_o}, 32'h0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule